// File: doc/BRIEF.md
# Packet-Aware Pixel Transform Stage

This stage sits in a video stream between a frame producer and a consumer. Both sides use a valid/ready handshake. Each side carries a 24-bit word and two framing flags, one for the first word of a packet and one for the last. The low four bits of each packet's first word give the packet type. Only packets of type 0 hold pixels. In those packets every word after the first goes through a per-pixel colour operation. By default the operation is a per-channel inversion: each 8-bit channel c becomes 255 - c. The header word is never changed. Control, ancillary and user packets pass through unchanged, so downstream cores still read frame dimensions and metadata correctly.

A three-state machine tracks where the stream is:

- ST_IDLE waits for a packet start.
- ST_VID covers the payload of a pixel packet.
- ST_AUX covers the payload of any other packet.

The transitions are:

- An accepted start word moves the machine to ST_VID when its type is 0, and to ST_AUX otherwise.
- An accepted end word returns the machine to ST_IDLE. A single-word packet, whose first word is also its last, goes straight back to ST_IDLE.
- An accepted start word seen in ST_VID or ST_AUX re-classifies the packet from that word.
- A word that is neither a start nor an end leaves the state unchanged.

The output side is one register deep. It accepts a new word in any cycle where the output is empty or the consumer takes the held word. This sustains one word per cycle.

Top module: `pkt_pixel_stage`

## Requirements
- R1: The input is ready exactly when the output holds no word or the consumer is ready. A word moves only in a cycle where valid and ready are both high.
- R2: While the output is valid and the consumer is not ready, the output word and its flags stay unchanged and the output stays valid.
- R3: A word that carries the start flag reaches the output bit-for-bit unchanged, whatever its type in bits 3:0 and whatever bits 23:4 hold.
- R4: In a packet whose start word has bits 3:0 equal to 0, every later word is output with each 8-bit channel (bits 23:16, 15:8, 7:0) replaced by 255 minus its value.
- R5: Every word of a packet with a type other than 0 (15 control, 13 ancillary, 1 to 8 user) reaches the output unchanged.
- R6: The start and end flags leave the stage in the same cycle as the data word they arrived with.
- R7: After an accepted end word the stage is idle, so a following word without the start flag passes unchanged.
- R8: A start word arriving in the middle of a packet begins a new packet, and the packet is re-classified from that word.
- R9: A synchronous active-low reset clears output-valid and returns the state machine to ST_IDLE.
- R10: With the consumer always ready, the stage accepts one word per cycle. The word appears at the output in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 24 | Input word |
| in_sop | input | 1 | Input first-word flag |
| in_eop | input | 1 | Input last-word flag |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Stage can accept a word |
| out_data | output | 24 | Output word |
| out_sop | output | 1 | Output first-word flag |
| out_eop | output | 1 | Output last-word flag |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |

## Verification
The assertions assume that the producer holds in_valid and the word steady until the word is accepted. They also assume that the framing flags mean something only when in_valid is high. The bench drives every word through a task that raises valid and keeps it and the word fixed until it sees ready. It never withdraws a pending word except by reset, and it drops valid once the word has gone. Packets start with a flagged header word. The only exceptions are deliberate ones: a stray word after an end, and a start word that cuts into an open packet. Both are legal cases that the requirements define.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    // Tracks whether the stream is between packets or inside the payload of one.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VID  = 2'd1,
        ST_AUX  = 2'd2
    } pxs_state_e;

    // Field layout of the header word.
    localparam int unsigned TYPE_W          = 4;
    localparam logic [TYPE_W-1:0] TYPE_PIXEL = 4'd0;

    // Selects which colour operation is built.
    localparam int unsigned OP_INVERT = 0;
    localparam int unsigned OP_SWAP   = 1;

endpackage

// File: rtl/pxs_classifier.sv
module pxs_classifier
    import pxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              sop,
    input  logic              eop,
    input  logic [TYPE_W-1:0] type_code,
    output logic              xform_en,
    output pxs_state_e        state_q
);

    pxs_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state. A start word is classified in any state, which covers re-classification in mid-packet.
    always_comb begin
        state_d = state_q;
        if (fire) begin
            if (sop) begin
                if (eop) begin
                    state_d = ST_IDLE;
                end else if (type_code == TYPE_PIXEL) begin
                    state_d = ST_VID;
                end else begin
                    state_d = ST_AUX;
                end
            end else begin
                unique case (state_q)
                    ST_IDLE: state_d = ST_IDLE;
                    ST_VID:  state_d = eop ? ST_IDLE : ST_VID;
                    ST_AUX:  state_d = eop ? ST_IDLE : ST_AUX;
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    // Outputs: a word is transformed only when it is a payload word of a pixel packet.
    always_comb begin
        xform_en = 1'b0;
        unique case (state_q)
            ST_IDLE: xform_en = 1'b0;
            ST_VID:  xform_en = !sop;
            ST_AUX:  xform_en = 1'b0;
            default: xform_en = 1'b0;
        endcase
    end

    // R7: an accepted last word leaves the machine idle.
    a_r7_eop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fire && eop |=> state_q == ST_IDLE);

    // R8: an accepted start word of pixel type, not also a last word, enters the pixel payload state.
    a_r8_sop_reclass: assert property (@(posedge clk) disable iff (!rst_n)
        fire && sop && !eop && type_code == TYPE_PIXEL |=> state_q == ST_VID);

endmodule

// File: rtl/pxs_colour_op.sv
module pxs_colour_op
    import pxs_pkg::*;
#(
    parameter int unsigned N_CH = 3,
    parameter int unsigned CH_W = 8,
    parameter int unsigned OP   = OP_INVERT
) (
    input  logic [N_CH*CH_W-1:0] pix_in,
    output logic [N_CH*CH_W-1:0] pix_out
);

    localparam logic [CH_W-1:0] CH_MAX = {CH_W{1'b1}};

    // One slice per colour channel; the parameter OP picks the operation.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        if (OP == OP_SWAP) begin : g_swap
            assign pix_out[c*CH_W +: CH_W] = pix_in[(N_CH-1-c)*CH_W +: CH_W];
        end else begin : g_inv
            assign pix_out[c*CH_W +: CH_W] = CH_MAX - pix_in[c*CH_W +: CH_W];
        end
    end

endmodule

// File: rtl/pxs_out_reg.sv
module pxs_out_reg #(
    parameter int unsigned W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_word,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_word,
    input  logic         out_ready
);

    // Ready passes straight through, so both ports have zero ready latency.
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
            out_word <= in_word;
        end
    end

    // R9: reset empties the output.
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R2: a stalled output word is held steady.
    a_r2_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word));

endmodule

// File: rtl/pkt_pixel_stage.sv
module pkt_pixel_stage
    import pxs_pkg::*;
#(
    parameter int unsigned N_CH = 3,
    parameter int unsigned CH_W = 8,
    parameter int unsigned OP   = OP_INVERT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CH*CH_W-1:0] in_data,
    input  logic                 in_sop,
    input  logic                 in_eop,
    input  logic                 in_valid,
    output logic                 in_ready,
    output logic [N_CH*CH_W-1:0] out_data,
    output logic                 out_sop,
    output logic                 out_eop,
    output logic                 out_valid,
    input  logic                 out_ready
);

    localparam int unsigned DATA_W = N_CH * CH_W;
    localparam int unsigned WORD_W = DATA_W + 2;

    logic              fire;
    logic              xform_en;
    pxs_state_e        state_q;
    logic [DATA_W-1:0] pix_new;
    logic [DATA_W-1:0] data_sel;
    logic [WORD_W-1:0] word_in;
    logic [WORD_W-1:0] word_out;

    assign fire = in_valid && in_ready;

    pxs_classifier u_cls (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .sop       (in_sop),
        .eop       (in_eop),
        .type_code (in_data[TYPE_W-1:0]),
        .xform_en  (xform_en),
        .state_q   (state_q)
    );

    pxs_colour_op #(.N_CH(N_CH), .CH_W(CH_W), .OP(OP)) u_op (
        .pix_in  (in_data),
        .pix_out (pix_new)
    );

    assign data_sel = xform_en ? pix_new : in_data;
    // R6: the flags travel in the same register as their data word.
    assign word_in  = {in_sop, in_eop, data_sel};

    pxs_out_reg #(.W(WORD_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (word_in),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_word  (word_out),
        .out_ready (out_ready)
    );

    assign out_sop  = word_out[WORD_W-1];
    assign out_eop  = word_out[WORD_W-2];
    assign out_data = word_out[DATA_W-1:0];

    // R3: a start word reaches the output unchanged, flags included.
    a_r3_header_intact: assert property (@(posedge clk) disable iff (!rst_n)
        fire && in_sop |=> out_valid && out_sop && out_data == $past(in_data)
                           && out_eop == $past(in_eop));

    // R10: an accepted word is presented on the next cycle.
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid);

    // R5: a payload word of an auxiliary packet is not altered.
    a_r5_aux_intact: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !in_sop && state_q == ST_AUX |=> out_data == $past(in_data));

endmodule

// File: tb/sim_pkt_pixel_stage.sv
module sim_pkt_pixel_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] out_data;
    logic        out_sop;
    logic        out_eop;
    logic        out_valid;
    logic        out_ready = 1'b1;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    logic [25:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pkt_pixel_stage u0 (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_valid(in_valid),
        .in_ready(in_ready),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .out_valid(out_valid),
        .out_ready(out_ready)
    );

    function automatic logic [23:0] inv(input logic [23:0] d);
        return {8'd255 - d[23:16], 8'd255 - d[15:8], 8'd255 - d[7:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // A word counted at a falling edge is taken at the next rising edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected output", {6'd0, out_sop, out_eop, out_data}, 32'hFFFF_FFFF);
            end else begin
                check(tag_q.pop_front(), {6'd0, out_sop, out_eop, out_data},
                      {6'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic expect_word(input string tag, input logic s, input logic e, input logic [23:0] d);
        exp_q.push_back({s, e, d});
        tag_q.push_back(tag);
    endtask

    task automatic push(input logic s, input logic e, input logic [23:0] d);
        in_data = d; in_sop = s; in_eop = e; in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(posedge clk);
        #1;
        check("R1 queue drained", exp_q.size(), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9 reset out_valid", out_valid, 0);
        check("R1 reset in_ready", in_ready, 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic t_video();
        expect_word("R3 video header", 1, 0, 24'h123450);
        push(1, 0, 24'h123450);
        expect_word("R4 pixel a", 0, 0, inv(24'h000000));
        push(0, 0, 24'h000000);
        expect_word("R4 pixel b", 0, 0, inv(24'hFF10A5));
        push(0, 0, 24'hFF10A5);
        expect_word("R6 pixel eop", 0, 1, inv(24'h7F8001));
        push(0, 1, 24'h7F8001);
        drain();
    endtask

    task automatic t_other();
        logic [3:0] types[4] = '{4'd15, 4'd13, 4'd1, 4'd8};
        foreach (types[k]) begin
            expect_word("R5 header", 1, 0, {20'hABCDE, types[k]});
            push(1, 0, {20'hABCDE, types[k]});
            expect_word("R5 payload", 0, 0, 24'h0055AA);
            push(0, 0, 24'h0055AA);
            expect_word("R5 payload eop", 0, 1, 24'hC3C3C3);
            push(0, 1, 24'hC3C3C3);
        end
        expect_word("R6 single word", 1, 1, 24'h000000);
        push(1, 1, 24'h000000);
        drain();
    endtask

    task automatic t_stray();
        expect_word("R3 header", 1, 0, 24'h000000);
        push(1, 0, 24'h000000);
        expect_word("R4 pixel eop", 0, 1, inv(24'h102030));
        push(0, 1, 24'h102030);
        expect_word("R7 stray word", 0, 0, 24'h102030);
        push(0, 0, 24'h102030);
        drain();
    endtask

    task automatic t_reclass();
        expect_word("R3 header", 1, 0, 24'h000000);
        push(1, 0, 24'h000000);
        expect_word("R4 pixel", 0, 0, inv(24'h111111));
        push(0, 0, 24'h111111);
        expect_word("R8 control header", 1, 0, 24'h00000F);
        push(1, 0, 24'h00000F);
        expect_word("R8 control payload", 0, 0, 24'h222222);
        push(0, 0, 24'h222222);
        expect_word("R8 video header", 1, 0, 24'hFFFFF0);
        push(1, 0, 24'hFFFFF0);
        expect_word("R8 pixel after reclass", 0, 1, inv(24'h333333));
        push(0, 1, 24'h333333);
        drain();
    endtask

    task automatic t_backpressure();
        out_ready = 1'b0;
        expect_word("R2 held word", 1, 0, 24'h00000D);
        push(1, 0, 24'h00000D);
        in_data = 24'h445566; in_sop = 1'b0; in_eop = 1'b1; in_valid = 1'b1;
        expect_word("R2 next word", 0, 1, 24'h445566);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 stalled in_ready", in_ready, 0);
            check("R2 stalled out_valid", out_valid, 1);
            check("R2 stalled data", out_data, 24'h00000D);
        end
        @(posedge clk); #1;
        out_ready = 1'b1;
        @(negedge clk);
        check("R1 released in_ready", in_ready, 1);
        @(posedge clk); #1;
        in_valid = 1'b0;
        drain();
    endtask

    task automatic t_throughput();
        int c0;
        c0 = cyc;
        expect_word("R10 header", 1, 0, 24'h000000);
        push(1, 0, 24'h000000);
        check("R10 latency valid", out_valid, 1);
        for (int i = 1; i < 5; i++) begin
            expect_word("R10 pixel", 0, i == 4, inv(24'h010101 * i));
            push(0, i == 4, 24'h010101 * i);
        end
        check("R10 five words in five cycles", cyc - c0, 5);
        drain();
    endtask

    task automatic t_mid_reset();
        out_ready = 1'b0;
        push(1, 0, 24'h000000);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        exp_q.delete();
        tag_q.delete();
        check("R9 reset clears valid", out_valid, 0);
        out_ready = 1'b1;
        expect_word("R9 idle after reset", 0, 0, 24'h0F0F0F);
        push(0, 0, 24'h0F0F0F);
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("R1 watchdog", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_video();
        t_other();
        t_stray();
        t_reclass();
        t_backpressure();
        t_throughput();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule